// File: doc/BRIEF.md
# Power-Good Aggregator

This block turns a set of per-rail voltage status flags into two independently configured power-good outputs. Each rail reports an undervoltage flag and an overvoltage flag. The block synchronises these flags, masks any rail that is switched off or not monitored, and applies a window setting that decides whether overvoltage counts as a fault. For each output, a selection mask then picks which of the qualified sources can pull that output inactive. The rails are the converter outputs, three input-rail monitors and a thermal warning.

Each output can wait a fixed time, derived from the clock frequency, before it asserts. It deasserts on the first cycle it sees a problem. Each output has its own polarity and can drive its pin push-pull or open-drain; open-drain is modelled as a pin value together with an output enable. A thermal-shutdown fault or an input-overvoltage fault forces both outputs to their inactive level whatever the monitors report.

Top module: `pg_aggregator`

## Requirements
- R1: The source vector is indexed with converters at bits 0..N_CONV-1 (bucks first, boost last), then the analog-supply input, then external monitors one and two, and the thermal warning in the top bit. A converter source counts as out of tolerance only when both its `conv_en` bit and its `cfg_mon_en` bit are 1. An input source needs only its `cfg_mon_en` bit (bit N_CONV+k). The thermal warning has no enable of its own.
- R2: With `cfg_window`=0 only undervoltage flags make a source out of tolerance. With `cfg_window`=1 an undervoltage flag or an overvoltage flag does.
- R3: Output p is affected only by the sources whose bit is 1 in its select mask (`cfg_sel0` or `cfg_sel1`). The masks are independent of each other.
- R4: An output is active only while no selected source is out of tolerance. It goes inactive on the clock edge after any selected source is seen out of tolerance.
- R5: When `cfg_dly_en[p]`=1, output p asserts only after DLY_CYC consecutive qualified-good cycles. A bad cycle while the delay is counting restarts the count from zero.
- R6: `cfg_pol[p]`=1 makes the active level high. `cfg_pol[p]`=0 makes the active level low.
- R7: With `cfg_od[p]`=1, `pg_pin[p]` is 0 and `pg_oe[p]` is the inverse of the output level, so the pin is released when the level is high. With `cfg_od[p]`=0, `pg_oe[p]` is 1 and `pg_pin[p]` equals the level.
- R8: A synchronised `fault_tsd` or `fault_inov` forces both outputs inactive.
- R9: While `rst_n`=0 both outputs are inactive and their delay counts are zero.
- R10: Raw flags pass through two flops. Without delay, a change on the inputs reaches `pg_pin` on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_uv | input | N_CONV | Converter undervoltage flags |
| conv_ov | input | N_CONV | Converter overvoltage flags |
| conv_en | input | N_CONV | Converter enabled bits |
| in_uv | input | N_IN | Input monitor undervoltage flags |
| in_ov | input | N_IN | Input monitor overvoltage flags |
| therm_warn | input | 1 | Thermal warning flag |
| fault_tsd | input | 1 | Thermal shutdown fault |
| fault_inov | input | 1 | Input overvoltage protection fault |
| cfg_mon_en | input | N_CONV+N_IN | Per-source monitor enables |
| cfg_window | input | 1 | 1 = undervoltage and overvoltage, 0 = undervoltage only |
| cfg_sel0 | input | N_SRC | Source select mask for output 0 |
| cfg_sel1 | input | N_SRC | Source select mask for output 1 |
| cfg_pol | input | 2 | Per-output polarity, 1 = active high |
| cfg_od | input | 2 | Per-output open-drain select |
| cfg_dly_en | input | 2 | Per-output rise-delay enable |
| pg_pin | output | 2 | Pin drive values |
| pg_oe | output | 2 | Pin output enables |

## Verification
The assertions check on every cycle that a fault or a selected bad source clears the output state on the next edge, and that an output only rises after a good cycle. They also check that, with the delay enabled, an output only rises once the count has reached its end, and that the count stays in range. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model. These cover the masking of disabled converters, the window setting, the split between the two select masks, and the polarity and open-drain pin encodings. They also cover the exact latency of 3 edges, or DLY_CYC+2 edges with the delay, and the restart of the count after a glitch.

// File: rtl/pg_pkg.sv
package pg_pkg;
  function automatic logic out_of_tol(input logic uv, input logic ov, input logic win);
    return uv | (win & ov);
  endfunction

  function automatic logic pin_level(input logic active, input logic pol);
    return pol ? active : ~active;
  endfunction

  function automatic int delay_cycles(input int clk_hz, input int delay_us);
    longint t;
    t = (longint'(clk_hz) / 1000) * longint'(delay_us) / 1000;
    return int'(t);
  endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pg_src_qual.sv
module pg_src_qual
  import pg_pkg::*;
#(
  parameter int N_CONV = 3,
  parameter int N_IN   = 3,
  localparam int N_SRC = N_CONV + N_IN + 1
) (
  input  logic [N_CONV-1:0]      conv_uv,
  input  logic [N_CONV-1:0]      conv_ov,
  input  logic [N_CONV-1:0]      conv_en,
  input  logic [N_IN-1:0]        in_uv,
  input  logic [N_IN-1:0]        in_ov,
  input  logic                   therm,
  input  logic [N_CONV+N_IN-1:0] mon_en,
  input  logic                   window,
  output logic [N_SRC-1:0]       bad
);
  // R1: converters need both enables, inputs need only the monitor enable
  for (genvar c = 0; c < N_CONV; c++) begin : g_conv
    assign bad[c] = conv_en[c] & mon_en[c] & out_of_tol(conv_uv[c], conv_ov[c], window);
  end
  for (genvar k = 0; k < N_IN; k++) begin : g_in
    assign bad[N_CONV+k] = mon_en[N_CONV+k] & out_of_tol(in_uv[k], in_ov[k], window);
  end
  assign bad[N_SRC-1] = therm;
endmodule

// File: rtl/pg_channel.sv
module pg_channel
  import pg_pkg::*;
#(
  parameter int N_SRC   = 7,
  parameter int DLY_CYC = 11000,
  localparam int CW     = $clog2(DLY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] bad,
  input  logic [N_SRC-1:0] sel,
  input  logic             fault,
  input  logic             pol,
  input  logic             od,
  input  logic             dly_en,
  output logic             pin,
  output logic             oe
);
  logic          active;
  logic [CW-1:0] cnt;
  logic          all_good;
  logic          cnt_done;
  logic          level;

  assign all_good = ~|(bad & sel) & ~fault;
  assign cnt_done = (cnt == CW'(DLY_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!all_good) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!dly_en) begin
      active <= 1'b1;
    end else if (cnt_done) begin
      active <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign level = pin_level(active, pol);
  assign pin   = od ? 1'b0 : level;
  assign oe    = od ? ~level : 1'b1;

  // R8
  fault_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !active);
  // R4
  bad_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bad & sel)) |=> (!active && cnt == '0));
  // R4
  rise_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(all_good));
  // R5
  rise_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && $past(dly_en)) |-> $past(cnt_done));
  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(DLY_CYC));
endmodule

// File: rtl/pg_aggregator.sv
module pg_aggregator
  import pg_pkg::*;
#(
  parameter int N_BUCK   = 2,
  parameter int N_IN     = 3,
  parameter int CLK_HZ   = 100_000_000,
  parameter int DELAY_US = 11000,
  localparam int N_CONV  = N_BUCK + 1,
  localparam int N_SRC   = N_CONV + N_IN + 1,
  localparam int N_MON   = N_CONV + N_IN,
  localparam int SYNC_W  = 2 * N_CONV + 2 * N_IN + 3,
  localparam int DLY_CYC = delay_cycles(CLK_HZ, DELAY_US)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CONV-1:0] conv_uv,
  input  logic [N_CONV-1:0] conv_ov,
  input  logic [N_CONV-1:0] conv_en,
  input  logic [N_IN-1:0]   in_uv,
  input  logic [N_IN-1:0]   in_ov,
  input  logic              therm_warn,
  input  logic              fault_tsd,
  input  logic              fault_inov,
  input  logic [N_MON-1:0]  cfg_mon_en,
  input  logic              cfg_window,
  input  logic [N_SRC-1:0]  cfg_sel0,
  input  logic [N_SRC-1:0]  cfg_sel1,
  input  logic [1:0]        cfg_pol,
  input  logic [1:0]        cfg_od,
  input  logic [1:0]        cfg_dly_en,
  output logic [1:0]        pg_pin,
  output logic [1:0]        pg_oe
);
  logic [N_CONV-1:0] s_conv_uv, s_conv_ov;
  logic [N_IN-1:0]   s_in_uv, s_in_ov;
  logic              s_therm, s_tsd, s_inov;
  logic [N_SRC-1:0]  src_bad;
  logic              fault_any;
  logic [1:0][N_SRC-1:0] sel_vec;

  // R10
  pg_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fault_inov, fault_tsd, therm_warn, in_ov, in_uv, conv_ov, conv_uv}),
    .q     ({s_inov, s_tsd, s_therm, s_in_ov, s_in_uv, s_conv_ov, s_conv_uv})
  );

  pg_src_qual #(.N_CONV(N_CONV), .N_IN(N_IN)) u_qual (
    .conv_uv (s_conv_uv),
    .conv_ov (s_conv_ov),
    .conv_en (conv_en),
    .in_uv   (s_in_uv),
    .in_ov   (s_in_ov),
    .therm   (s_therm),
    .mon_en  (cfg_mon_en),
    .window  (cfg_window),
    .bad     (src_bad)
  );

  assign fault_any = s_tsd | s_inov;
  assign sel_vec   = {cfg_sel1, cfg_sel0};

  for (genvar p = 0; p < 2; p++) begin : g_out
    pg_channel #(.N_SRC(N_SRC), .DLY_CYC(DLY_CYC)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .bad    (src_bad),
      .sel    (sel_vec[p]),
      .fault  (fault_any),
      .pol    (cfg_pol[p]),
      .od     (cfg_od[p]),
      .dly_en (cfg_dly_en[p]),
      .pin    (pg_pin[p]),
      .oe     (pg_oe[p])
    );
  end
endmodule

// File: tb/pg_aggregator_tb.sv
module pg_aggregator_tb;
  localparam int N_BUCK = 2;
  localparam int N_IN   = 3;
  localparam int N_CONV = N_BUCK + 1;
  localparam int N_SRC  = N_CONV + N_IN + 1;
  localparam int N_MON  = N_CONV + N_IN;
  // Delay parameter set as for a 1 MHz clock: 11 ms -> 11000 cycles
  localparam int DLY    = 11000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_CONV-1:0] conv_uv = '0, conv_ov = '0, conv_en = '1;
  logic [N_IN-1:0]   in_uv = '0, in_ov = '0;
  logic therm_warn = 1'b0, fault_tsd = 1'b0, fault_inov = 1'b0;
  logic [N_MON-1:0] cfg_mon_en = '1;
  logic cfg_window = 1'b0;
  logic [N_SRC-1:0] cfg_sel0 = '1, cfg_sel1 = '1;
  logic [1:0] cfg_pol = 2'b11, cfg_od = 2'b00, cfg_dly_en = 2'b00;
  logic [1:0] pg_pin, pg_oe;

  int tests = 0, fails = 0;
  string cur_req = "R9";
  bit finished = 0;

  always #5 clk = ~clk;

  pg_aggregator #(.N_BUCK(N_BUCK), .N_IN(N_IN), .CLK_HZ(1_000_000), .DELAY_US(11000)) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_uv(conv_uv), .conv_ov(conv_ov), .conv_en(conv_en),
    .in_uv(in_uv), .in_ov(in_ov), .therm_warn(therm_warn), .fault_tsd(fault_tsd),
    .fault_inov(fault_inov), .cfg_mon_en(cfg_mon_en), .cfg_window(cfg_window),
    .cfg_sel0(cfg_sel0), .cfg_sel1(cfg_sel1), .cfg_pol(cfg_pol), .cfg_od(cfg_od),
    .cfg_dly_en(cfg_dly_en), .pg_pin(pg_pin), .pg_oe(pg_oe));

  // Behavioural reference: flags delayed by a two-entry history, integer counters
  typedef struct {
    bit [N_CONV-1:0] cuv, cov;
    bit [N_IN-1:0]   iuv, iov;
    bit th, tsd, inov;
  } flags_t;
  flags_t hist[$];
  int  m_cnt[2];
  bit  m_act[2];

  function automatic flags_t sample_now();
    flags_t f;
    f.cuv = conv_uv; f.cov = conv_ov; f.iuv = in_uv; f.iov = in_ov;
    f.th = therm_warn; f.tsd = fault_tsd; f.inov = fault_inov;
    return f;
  endfunction

  function automatic bit src_is_bad(flags_t f, int i);
    bit u, o;
    if (i == N_SRC - 1) return f.th;
    if (i < N_CONV) begin
      u = f.cuv[i]; o = f.cov[i];
      if (!(conv_en[i] && cfg_mon_en[i])) return 0;
    end else begin
      u = f.iuv[i-N_CONV]; o = f.iov[i-N_CONV];
      if (!cfg_mon_en[i]) return 0;
    end
    if (cfg_window) return u || o;
    return u;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      for (int k = 0; k < 2; k++) begin
        flags_t z;
        z = '{default: '0};
        hist.push_back(z);
      end
      m_cnt[0] = 0; m_cnt[1] = 0; m_act[0] = 0; m_act[1] = 0;
    end else begin
      flags_t old;
      old = hist[0];
      for (int p = 0; p < 2; p++) begin
        bit any_bad;
        any_bad = old.tsd || old.inov;
        for (int i = 0; i < N_SRC; i++)
          if (src_is_bad(old, i) && (p == 0 ? cfg_sel0[i] : cfg_sel1[i])) any_bad = 1;
        if (any_bad) begin
          m_act[p] = 0; m_cnt[p] = 0;
        end else if (!cfg_dly_en[p]) begin
          m_act[p] = 1;
        end else if (m_cnt[p] == DLY - 1) begin
          m_act[p] = 1;
        end else begin
          m_cnt[p] = m_cnt[p] + 1;
        end
      end
      void'(hist.pop_front());
      hist.push_back(sample_now());
    end
  end

  function automatic bit exp_pin(int p);
    bit lvl;
    lvl = cfg_pol[p] ? m_act[p] : !m_act[p];
    return cfg_od[p] ? 1'b0 : lvl;
  endfunction
  function automatic bit exp_oe(int p);
    bit lvl;
    lvl = cfg_pol[p] ? m_act[p] : !m_act[p];
    return cfg_od[p] ? !lvl : 1'b1;
  endfunction

  task automatic check_bit(string req, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      for (int p = 0; p < 2; p++) begin
        check_bit(cur_req, $sformatf("model pin%0d", p), pg_pin[p], exp_pin(p));
        check_bit(cur_req, $sformatf("model oe%0d", p), pg_oe[p], exp_oe(p));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Count rising edges until pg_pin[p] equals v
  task automatic wait_edges(int p, logic v, int limit, output int n);
    n = 0;
    while (pg_pin[p] !== v && n < limit) begin
      @(posedge clk); #1; n++;
    end
  endtask

  int n;

  initial begin
    // R9: reset state, active-high push-pull -> pin 0, oe 1
    cur_req = "R9";
    #12;
    check_bit("R9", "reset pin0", pg_pin[0], 1'b0);
    check_bit("R9", "reset oe0", pg_oe[0], 1'b1);
    check_bit("R9", "reset pin1", pg_pin[1], 1'b0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R10, R4: all good, no delay -> active after 3 edges
    cur_req = "R10";
    step(5);
    conv_uv[0] = 1'b1; step(4);
    check_bit("R4", "bad rail pin0", pg_pin[0], 1'b0);
    conv_uv[0] = 1'b0;
    wait_edges(0, 1'b1, 20, n);
    check_bit("R10", "latency ok", n == 3, 1'b1);
    conv_uv[0] = 1'b1;
    wait_edges(0, 1'b0, 20, n);
    check_bit("R4", "deassert latency", n == 3, 1'b1);
    conv_uv[0] = 1'b0; step(4);

    // R1: disabled converter and unmonitored inputs are masked
    cur_req = "R1";
    conv_uv[1] = 1'b1; step(4);
    check_bit("R1", "enabled conv bad", pg_pin[0], 1'b0);
    conv_en[1] = 1'b0; step(4);
    check_bit("R1", "disabled conv masked", pg_pin[0], 1'b1);
    conv_en[1] = 1'b1; cfg_mon_en[1] = 1'b0; step(4);
    check_bit("R1", "unmonitored conv masked", pg_pin[0], 1'b1);
    conv_uv[1] = 1'b0; cfg_mon_en[1] = 1'b1;
    in_uv[2] = 1'b1; step(4);
    check_bit("R1", "mon2 bad", pg_pin[1], 1'b0);
    cfg_mon_en[N_CONV+2] = 1'b0; step(4);
    check_bit("R1", "mon2 masked", pg_pin[1], 1'b1);
    in_uv[2] = 1'b0; cfg_mon_en = '1; step(4);

    // R2: window mode
    cur_req = "R2";
    conv_ov[2] = 1'b1; step(4);
    check_bit("R2", "ov ignored win0", pg_pin[0], 1'b1);
    cfg_window = 1'b1; step(4);
    check_bit("R2", "ov counts win1", pg_pin[0], 1'b0);
    conv_ov[2] = 1'b0; cfg_window = 1'b0; step(4);

    // R3: independent select masks, thermal warning in bit N_SRC-1
    cur_req = "R3";
    cfg_sel0[N_SRC-1] = 1'b0;
    therm_warn = 1'b1; step(4);
    check_bit("R3", "pg0 unaffected", pg_pin[0], 1'b1);
    check_bit("R3", "pg1 affected", pg_pin[1], 1'b0);
    therm_warn = 1'b0; cfg_sel0 = '1; step(4);

    // R6, R7: polarity and drive type
    cur_req = "R6";
    cfg_pol = 2'b10; step(1);
    check_bit("R6", "active-low pin0", pg_pin[0], 1'b0);
    cur_req = "R7";
    cfg_od = 2'b11; step(1);
    check_bit("R7", "od pin1", pg_pin[1], 1'b0);
    check_bit("R7", "od released oe1", pg_oe[1], 1'b0);
    check_bit("R7", "od driven oe0", pg_oe[0], 1'b1);
    cfg_pol = 2'b11; cfg_od = 2'b00; step(2);

    // R8: faults force both inactive
    cur_req = "R8";
    fault_tsd = 1'b1; step(4);
    check_bit("R8", "tsd pin0", pg_pin[0], 1'b0);
    check_bit("R8", "tsd pin1", pg_pin[1], 1'b0);
    fault_tsd = 1'b0; step(4);
    fault_inov = 1'b1; cfg_sel0 = '0; step(4);
    check_bit("R8", "inov pin0 empty sel", pg_pin[0], 1'b0);
    fault_inov = 1'b0; cfg_sel0 = '1; step(4);

    // R5: rise delay on output 0 only
    cur_req = "R5";
    cfg_dly_en = 2'b01;
    conv_uv[0] = 1'b1; step(4);
    conv_uv[0] = 1'b0;
    wait_edges(0, 1'b1, DLY + 50, n);
    check_bit("R5", "delayed rise edges", n == DLY + 2, 1'b1);
    // restart: glitch midway through the count
    conv_uv[0] = 1'b1; step(1); conv_uv[0] = 1'b0;
    step(5000);
    conv_uv[0] = 1'b1; step(1); conv_uv[0] = 1'b0;
    step(DLY - 10);
    check_bit("R5", "count restarted", pg_pin[0], 1'b0);
    wait_edges(0, 1'b1, 100, n);
    check_bit("R5", "rise after restart", pg_pin[0], 1'b1);
    step(3);

    // R9: mid-run reset
    cur_req = "R9";
    rst_n = 1'b0; #1;
    check_bit("R9", "reset clears pin0", pg_pin[0], 1'b0);
    step(2); rst_n = 1'b1; step(2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule